// File: doc/BRIEF.md
# Pipelined Burst SRAM Cycle Controller

This block is the synchronous front end of a small on-chip SRAM made of 32-bit words in four byte lanes. On each rising clock edge it looks at two address strobes, one for a processor and one for a bus controller, plus a burst-advance input, three chip enables and the write enables. From these it decides whether the edge is a deselect, the start of a read, the start of a write, a burst continue or a burst suspend. A continue steps the two low address bits through a four-beat sequence. A suspend repeats the current beat.

Reads pass through two register stages. The access address is captured on one edge, and the output register loads the word on the next edge. The data bus is split into a write-data input, a read-data output and an output-valid flag. The flag already includes the asynchronous, active-low output enable, so a pad ring or an on-chip bus can use it to gate the read data.

Top module: `sram_burst_fe`

## Requirements
- R1: When the processor strobe is low and the master enable is low on an edge, that edge starts a read at `addr` if `ceHigh`=1 and `ceLowN`=0. This holds whatever the write enables and the controller strobe show.
- R2: When the master enable is high, the processor strobe has no effect. A controller strobe low with the master enable high is a deselect. With the master enable high and the controller strobe high, the edge is handled as a continue or a suspend.
- R3: A controller strobe low with the processor strobe high and all three enables active starts an access at `addr`. The access is a write if the write command is present on that edge, and a read otherwise.
- R4: The write command is `globalWrN`=0, which writes all four lanes, or `byteWrEnN`=0 with at least one `laneEnN` bit low. In the second case only those lanes are written (lane i is bits 8i+7..8i). With `byteWrEnN`=0 and all lane bits high, the edge is a read.
- R5: On an edge with both strobes high during an active burst, `advanceN`=0 moves to the next burst address and `advanceN`=1 stays on the current one. The write command on that edge selects write or read.
- R6: Burst addresses change only bits [1:0]. Beat n of a burst that starts at s is (s+n) mod 4 when `burstLinear`=1, and s XOR n when `burstLinear`=0.
- R7: A word read at an address captured on edge k is presented on `rdData` after edge k+1.
- R8: `rdDataOe` is 1 only when `outEnN` is low, read data from R7 is pending, and the most recent edge was not a write.
- R9: On a strobe edge, an inactive chip enable gives a deselect. A deselect writes nothing, and `rdDataOe` is 0 from the second edge after it.
- R10: After the synchronous active-high `rst`, `rdDataOe` is 0 and no burst is active.
- R11: Continue and suspend edges that come while no burst is active (after a reset or a deselect) neither read nor write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 6 | Word address, sampled on strobe edges |
| procStrobeN | input | 1 | Processor address strobe, active low |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| ceMasterN | input | 1 | Master chip enable, active low |
| ceHigh | input | 1 | Chip enable, active high |
| ceLowN | input | 1 | Chip enable, active low |
| globalWrN | input | 1 | Write all lanes, active low |
| byteWrEnN | input | 1 | Enables per-lane writes, active low |
| laneEnN | input | 4 | Per-lane write selects, active low |
| burstLinear | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| outEnN | input | 1 | Asynchronous output enable, active low |
| wrData | input | 32 | Write data, sampled on write edges |
| rdData | output | 32 | Output register contents |
| rdDataOe | output | 1 | 1 when rdData should be driven |

## Verification
The bench checks the exact edge on which read data becomes valid. A design with one register too few or too many would show data one cycle early or late. Other cases it covers:
- Write enables presented on a processor-strobe edge. A design that took them would write memory.
- A controller strobe with the master enable high. A design that let it start an access would corrupt data.
- A processor strobe with the master enable high. It must fall through to a continue.
- Partial lane writes. A lane mix-up leaves the wrong bytes changed.
- Bursts in both orders, including a suspend in the middle. A wrong sequence or a suspend that advances returns the wrong word.
- The output gate around writes and the output enable, and advances after a deselect. A design that still drives the bus here would cause contention or stale reads.

// File: rtl/sram_fe_pkg.sv
package sram_fe_pkg;
  parameter int FE_LANES = 4;
  parameter int SEQ_W = 2;

  typedef struct packed {
    logic                loadAddr;
    logic                stepBurst;
    logic                deselect;
    logic                doRead;
    logic                doWrite;
    logic [FE_LANES-1:0] laneWr;
  } feCtl_t;
endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int SEQ_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             linear,
  input  logic [SEQ_W-1:0] startIn,
  output logic [SEQ_W-1:0] curLow,
  output logic [SEQ_W-1:0] nextLow
);
  logic [SEQ_W-1:0] startQ;
  logic [SEQ_W-1:0] cntQ;
  logic [SEQ_W-1:0] cntNext;

  assign cntNext = cntQ + 1'b1;

  always_comb begin
    if (linear) begin
      curLow  = startQ + cntQ;
      nextLow = startQ + cntNext;
    end else begin
      curLow  = startQ ^ cntQ;
      nextLow = startQ ^ cntNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      startQ <= '0;
      cntQ   <= '0;
    end else if (load) begin
      startQ <= startIn;
      cntQ   <= '0;
    end else if (step) begin
      cntQ <= cntNext;
    end
  end

  // R5
  hold_keeps_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(curLow));

  // R6
  step_takes_next_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (curLow == $past(nextLow)));
endmodule

// File: rtl/fe_ctrl.sv
module fe_ctrl
  import sram_fe_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                procStrobeN,
  input  logic                ctrlStrobeN,
  input  logic                advanceN,
  input  logic                ceMasterN,
  input  logic                ceHigh,
  input  logic                ceLowN,
  input  logic                globalWrN,
  input  logic                byteWrEnN,
  input  logic [FE_LANES-1:0] laneEnN,
  output feCtl_t              ctl
);
  logic activeQ;
  logic enablesOk;
  logic wrCmd;
  logic [FE_LANES-1:0] laneSel;

  assign enablesOk = !ceMasterN && ceHigh && !ceLowN;
  assign wrCmd     = !globalWrN || (!byteWrEnN && (laneEnN != '1));

  always_comb begin
    if (!globalWrN)      laneSel = '1;
    else if (!byteWrEnN) laneSel = ~laneEnN;
    else                 laneSel = '0;
  end

  always_comb begin
    ctl = '0;
    if (!ctrlStrobeN && ceMasterN) begin
      ctl.deselect = 1'b1;
    end else if (!procStrobeN && !ceMasterN) begin
      if (enablesOk) begin
        ctl.loadAddr = 1'b1;
        ctl.doRead   = 1'b1;
      end else begin
        ctl.deselect = 1'b1;
      end
    end else if (!ctrlStrobeN) begin
      if (enablesOk) begin
        ctl.loadAddr = 1'b1;
        ctl.doWrite  = wrCmd;
        ctl.doRead   = !wrCmd;
        ctl.laneWr   = wrCmd ? laneSel : '0;
      end else begin
        ctl.deselect = 1'b1;
      end
    end else if (activeQ) begin
      ctl.stepBurst = !advanceN;
      ctl.doWrite   = wrCmd;
      ctl.doRead    = !wrCmd;
      ctl.laneWr    = wrCmd ? laneSel : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               activeQ <= 1'b0;
    else if (ctl.loadAddr) activeQ <= 1'b1;
    else if (ctl.deselect) activeQ <= 1'b0;
  end

  // R1
  proc_edge_reads_chk: assert property (@(posedge clk) disable iff (rst)
    (!procStrobeN && !ceMasterN) |-> !ctl.doWrite);

  // R2
  master_blocks_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    (ceMasterN && !ctrlStrobeN) |-> !(ctl.doRead || ctl.doWrite));

  // R11
  idle_after_desel_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.deselect |=> (!(ctl.doRead || ctl.doWrite) || ctl.loadAddr));

  // R9
  one_kind_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.loadAddr, ctl.stepBurst, ctl.deselect}));
endmodule

// File: rtl/fe_data.sv
module fe_data
  import sram_fe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  feCtl_t                     ctl,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [SEQ_W-1:0]           curLow,
  input  logic [SEQ_W-1:0]           nextLow,
  input  logic [FE_LANES*LANE_W-1:0] wrData,
  input  logic                       outEnN,
  output logic [FE_LANES*LANE_W-1:0] rdData,
  output logic                       rdDataOe
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:SEQ_W] baseHiQ;
  logic [ADDR_W-1:0]     effAddr;
  logic [ADDR_W-1:0]     accAddrQ;
  logic                  rdReqQ;
  logic                  outValidQ;
  logic                  wrSeenQ;

  assign effAddr = ctl.loadAddr  ? addr :
                   ctl.stepBurst ? {baseHiQ, nextLow} : {baseHiQ, curLow};

  always_ff @(posedge clk) begin
    if (ctl.loadAddr) baseHiQ <= addr[ADDR_W-1:SEQ_W];
    if (ctl.doRead || ctl.doWrite) accAddrQ <= effAddr;
  end

  for (genvar g = 0; g < FE_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (ctl.doWrite && ctl.laneWr[g])
        laneMem[effAddr] <= wrData[g*LANE_W +: LANE_W];
      rdData[g*LANE_W +: LANE_W] <= laneMem[accAddrQ];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdReqQ    <= 1'b0;
      outValidQ <= 1'b0;
      wrSeenQ   <= 1'b0;
    end else begin
      rdReqQ    <= ctl.doRead;
      outValidQ <= rdReqQ;
      wrSeenQ   <= ctl.doWrite;
    end
  end

  assign rdDataOe = outValidQ && !outEnN && !wrSeenQ;

  // R8
  write_mutes_bus_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.doWrite |=> !rdDataOe);

  // R7
  read_reaches_out_chk: assert property (@(posedge clk) disable iff (rst)
    rdReqQ |=> outValidQ);
endmodule

// File: rtl/sram_burst_fe.sv
module sram_burst_fe
  import sram_fe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       procStrobeN,
  input  logic                       ctrlStrobeN,
  input  logic                       advanceN,
  input  logic                       ceMasterN,
  input  logic                       ceHigh,
  input  logic                       ceLowN,
  input  logic                       globalWrN,
  input  logic                       byteWrEnN,
  input  logic [FE_LANES-1:0]        laneEnN,
  input  logic                       burstLinear,
  input  logic                       outEnN,
  input  logic [FE_LANES*LANE_W-1:0] wrData,
  output logic [FE_LANES*LANE_W-1:0] rdData,
  output logic                       rdDataOe
);
  feCtl_t           ctl;
  logic [SEQ_W-1:0] curLow;
  logic [SEQ_W-1:0] nextLow;

  fe_ctrl u_ctrl (
    .clk(clk), .rst(rst), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .ceMasterN(ceMasterN), .ceHigh(ceHigh), .ceLowN(ceLowN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneEnN(laneEnN), .ctl(ctl)
  );

  burst_seq #(.SEQ_W(SEQ_W)) u_seq (
    .clk(clk), .rst(rst), .load(ctl.loadAddr), .step(ctl.stepBurst),
    .linear(burstLinear), .startIn(addr[SEQ_W-1:0]), .curLow(curLow), .nextLow(nextLow)
  );

  fe_data #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_data (
    .clk(clk), .rst(rst), .ctl(ctl), .addr(addr), .curLow(curLow), .nextLow(nextLow),
    .wrData(wrData), .outEnN(outEnN), .rdData(rdData), .rdDataOe(rdDataOe)
  );

  // R9
  desel_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.deselect |=> ##1 !rdDataOe);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !rdDataOe);
endmodule

// File: tb/sram_burst_fe_tb.sv
module sram_burst_fe_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  addr = '0;
  logic        procStrobeN = 1'b1, ctrlStrobeN = 1'b1, advanceN = 1'b1;
  logic        ceMasterN = 1'b0, ceHigh = 1'b1, ceLowN = 1'b0;
  logic        globalWrN = 1'b1, byteWrEnN = 1'b1;
  logic [3:0]  laneEnN = 4'hF;
  logic        burstLinear = 1'b0, outEnN = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdDataOe;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [31:0] memM [64];
  bit          activeM, rdReqM, outValidM, wrSeenM;
  logic [5:0]  baseM, accM;
  int          startM, cntM;
  logic [31:0] outM;

  sram_burst_fe dut_i (
    .clk(clk), .rst(rst), .addr(addr), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .ceMasterN(ceMasterN), .ceHigh(ceHigh), .ceLowN(ceLowN),
    .globalWrN(globalWrN), .byteWrEnN(byteWrEnN), .laneEnN(laneEnN), .burstLinear(burstLinear),
    .outEnN(outEnN), .wrData(wrData), .rdData(rdData), .rdDataOe(rdDataOe)
  );

  always #10 clk = ~clk;

  function automatic int beat(int s, int n);
    if (burstLinear) return (s + n) % 4;
    return s ^ n;
  endfunction

  task automatic modelEdge();
    bit rd = 0, wr = 0, ld = 0, ds = 0;
    bit enOk, cmd;
    logic [3:0] lanes;
    logic [5:0] eff;
    enOk = !ceMasterN && ceHigh && !ceLowN;
    cmd = !globalWrN || (!byteWrEnN && laneEnN != 4'hF);
    lanes = !globalWrN ? 4'hF : (!byteWrEnN ? ~laneEnN : 4'h0);
    eff = accM;
    if (rst) begin
      activeM = 0; rdReqM = 0; outValidM = 0; wrSeenM = 0; startM = 0; cntM = 0;
      return;
    end
    if (!ctrlStrobeN && ceMasterN) ds = 1;
    else if (!procStrobeN && !ceMasterN) begin
      if (enOk) begin ld = 1; rd = 1; end else ds = 1;
    end else if (!ctrlStrobeN) begin
      if (enOk) begin ld = 1; wr = cmd; rd = !cmd; end else ds = 1;
    end else if (activeM) begin
      if (!advanceN) cntM = (cntM + 1) % 4;
      wr = cmd; rd = !cmd;
      eff = {baseM[5:2], 2'(beat(startM, cntM))};
    end
    if (ld) begin
      baseM = addr; startM = int'(addr[1:0]); cntM = 0; eff = addr; activeM = 1;
    end
    if (ds) activeM = 0;
    outValidM = rdReqM;
    outM = memM[accM];
    wrSeenM = wr;
    rdReqM = rd;
    if (rd || wr) accM = eff;
    if (wr) for (int i = 0; i < 4; i++)
      if (lanes[i]) memM[eff][i*8 +: 8] = wrData[i*8 +: 8];
  endtask

  task automatic cyc(input string tag);
    bit expOe;
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    expOe = outValidM && !outEnN && !wrSeenM;
    checks++;
    if (rdDataOe !== expOe) begin
      fails++;
      $display("FAIL %s: rdDataOe=%b expected %b at %0t", tag, rdDataOe, expOe, $time);
    end
    if (expOe) begin
      checks++;
      if (rdData !== outM) begin
        fails++;
        $display("FAIL %s: rdData=%h expected %h at %0t", tag, rdData, outM, $time);
      end
    end
  endtask

  task automatic idle();
    procStrobeN = 1; ctrlStrobeN = 1; advanceN = 1;
    ceMasterN = 0; ceHigh = 1; ceLowN = 0;
    globalWrN = 1; byteWrEnN = 1; laneEnN = 4'hF; outEnN = 0;
  endtask

  task automatic ctrlAccess(input logic [5:0] a, input logic [31:0] d, input logic g,
                            input logic b, input logic [3:0] l, input string tag);
    idle(); ctrlStrobeN = 0; addr = a; wrData = d; globalWrN = g; byteWrEnN = b; laneEnN = l;
    cyc(tag);
  endtask

  task automatic procRead(input logic [5:0] a, input string tag);
    idle(); procStrobeN = 0; addr = a;
    cyc(tag);
  endtask

  task automatic burstEdge(input logic adv, input string tag);
    idle(); advanceN = adv;
    cyc(tag);
  endtask

  task automatic doReset();
    rst = 1; idle(); cyc("R10"); cyc("R10"); rst = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle();
    doReset();
    // R10: quiet after reset
    checks++;
    if (rdDataOe !== 1'b0) begin fails++; $display("FAIL R10: rdDataOe=%b expected 0", rdDataOe); end
    // R11: advance with no burst active
    burstEdge(0, "R11"); burstEdge(0, "R11");

    // R3 R4: fill memory with global writes
    for (int i = 0; i < 64; i++) ctrlAccess(6'(i), 32'hA500_0000 + i * 32'h0001_0203, 0, 1, 4'hF, "R3");
    // R3 R7: controller reads back
    for (int i = 0; i < 8; i++) ctrlAccess(6'(i * 7), '0, 1, 1, 4'hF, "R7");
    idle(); cyc("R7"); cyc("R7");

    // R4: lane writes, then global write ignoring lanes, then no-lane byte enable = read
    ctrlAccess(6'd5, 32'h1122_3344, 1, 0, 4'b1010, "R4");
    ctrlAccess(6'd6, 32'h5566_7788, 0, 0, 4'b1110, "R4");
    ctrlAccess(6'd7, 32'hDEAD_BEEF, 1, 0, 4'hF, "R4");
    procRead(6'd5, "R4"); procRead(6'd6, "R4"); procRead(6'd7, "R4");

    // R1: write enables and controller strobe on a processor edge are ignored
    idle(); procStrobeN = 0; ctrlStrobeN = 0; globalWrN = 0; addr = 6'd9; wrData = 32'hFFFF_FFFF;
    cyc("R1");
    procRead(6'd9, "R1"); idle(); cyc("R1"); cyc("R1");

    // R5 R6: interleaved burst with a suspend, starting at beat 2
    procRead(6'd14, "R6");
    burstEdge(0, "R6"); burstEdge(1, "R5"); burstEdge(1, "R5");
    burstEdge(0, "R6"); burstEdge(0, "R6"); burstEdge(1, "R5");
    // R5: burst write after processor read; lane selects apply on later edges
    idle(); procStrobeN = 0; addr = 6'd21; byteWrEnN = 0; laneEnN = 4'h0; cyc("R1");
    idle(); advanceN = 0; byteWrEnN = 0; laneEnN = 4'b0110; wrData = 32'hCAFE_F00D; cyc("R5");
    idle(); globalWrN = 0; wrData = 32'h0BAD_C0DE; cyc("R5");
    procRead(6'd20, "R5"); burstEdge(0, "R6"); burstEdge(0, "R6"); burstEdge(0, "R6");

    // R8: output enable high hides data
    procRead(6'd3, "R8"); idle(); outEnN = 1; cyc("R8"); cyc("R8"); outEnN = 0; cyc("R8");

    // R2: controller strobe with master enable off is a deselect
    procRead(6'd30, "R2");
    idle(); ctrlStrobeN = 0; ceMasterN = 1; addr = 6'd31; globalWrN = 0; wrData = 32'h0; cyc("R2");
    idle(); cyc("R9"); cyc("R11"); burstEdge(0, "R11");
    procRead(6'd31, "R2"); idle(); cyc("R2");
    // R2: processor strobe with master enable off acts as a continue
    procRead(6'd40, "R2");
    idle(); procStrobeN = 0; ceMasterN = 1; addr = 6'd1; advanceN = 0; cyc("R2");
    burstEdge(1, "R2"); idle(); cyc("R2");

    // R9: other enables inactive on strobe edges
    procRead(6'd12, "R9");
    idle(); procStrobeN = 0; ceHigh = 0; addr = 6'd13; cyc("R9");
    idle(); cyc("R9"); cyc("R9");
    procRead(6'd12, "R9");
    idle(); ctrlStrobeN = 0; ceLowN = 1; globalWrN = 0; addr = 6'd12; wrData = 32'h1; cyc("R9");
    idle(); cyc("R9"); procRead(6'd12, "R9"); idle(); cyc("R9"); cyc("R9");

    // R6: linear order
    burstLinear = 1; doReset();
    procRead(6'd45, "R6");
    burstEdge(0, "R6"); burstEdge(0, "R6"); burstEdge(0, "R6"); burstEdge(0, "R6");
    procRead(6'd50, "R6");
    burstEdge(0, "R6"); burstEdge(1, "R5"); burstEdge(0, "R6"); idle(); cyc("R6");

    // R10: reset in mid-burst
    procRead(6'd8, "R10"); rst = 1; idle(); cyc("R10"); rst = 0;
    checks++;
    if (rdDataOe !== 1'b0) begin fails++; $display("FAIL R10: rdDataOe=%b expected 0", rdDataOe); end
    burstEdge(0, "R11"); burstEdge(0, "R11");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule